// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single timer channel. A 32-bit counter steps down by one on every prescaled tick. When a tick finds the counter at zero, the counter takes the value held in a reload register and a sticky underflow flag is set. The tick rate is the block clock divided by 4, 16, 64, 256 or 1024, as chosen in a control register. An external run input starts counting, and lowering it freezes the channel. An interrupt output is raised while the flag is set and its enable bit is on.

Software reaches four word registers through a plain write strobe, a byte address and a combinational read port. Address bits [3:2] select the register. The fourth register is a plain storage word and has no capture function. The flag cannot be set by software. Writing control bit 8 as zero clears it. Control reads show the live flag in bit 8.

Top module: `tmr_channel`

## Requirements
- R1: After reset the reload register and the counter read 0xFFFFFFFF. The control and storage registers read 0, irq_o is low and the channel is stopped.
- R2: Address bits [3:2] select the register: 0 is reload, 1 is counter, 2 is control and 3 is storage. A write to storage reads back unchanged, and a write to reload reads back unchanged.
- R3: Control bits [2:0] hold the prescale code, and codes 0 to 4 divide by 4, 16, 64, 256 and 1024. The channel keeps one phase count of the cycles that advance the prescaler, counted since reset. A tick occurs in a cycle that advances the prescaler when that count, modulo the divisor, equals divisor minus one.
- R4: A tick decrements a nonzero counter by one. A tick that finds the counter at zero loads the reload value and sets the underflow flag.
- R5: While run_i is low the counter and the prescaler phase hold their values. Counting resumes from those values when run_i rises.
- R6: In a cycle with a control write there is no tick and the prescaler phase does not advance. The count is kept.
- R7: A control write with bit 8 at 0 clears the underflow flag. A control write with bit 8 at 1 leaves the flag unchanged.
- R8: A control read returns the stored bits [7:0], the live flag in bit 8, and zero in bits [31:9]. Written prescale codes 5 to 7 are stored as 0. Written bits [15:9] are dropped.
- R9: irq_o is high exactly when the underflow flag is set and control bit 5 is set.
- R10: A counter write loads the counter directly. When it falls in the same cycle as a tick, the write wins and the flag is not set.
- R11: A reload write changes the value used at later underflows. An underflow in the same cycle as the reload write loads the old reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Count enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address; bits [3:2] select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Underflow interrupt |

## Verification
A software write can land in the very cycle in which a tick underflows the counter. A counter write must then win with no flag set, and a reload write must leave the old reload value as the one loaded. The bench runs a cycle model of the phase count and steps the channel until the model predicts that the next edge carries a zero-count tick. It then issues the write in exactly that cycle and compares the counter, the control read-back and irq_o with the model afterwards.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CTL_W    = 16;
  localparam int unsigned PSEL_W   = 3;
  localparam int unsigned IE_BIT   = 5;
  localparam int unsigned UF_BIT   = 8;
  localparam logic [CTL_W-1:0] CTL_STORE_MASK = 16'h00FF;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STORE  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned NUM_DIV = 5,
  parameter int unsigned SEL_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned PH_W    = 2 * NUM_DIV;
  localparam int unsigned NUM_SEL = 1 << SEL_W;

  logic [PH_W-1:0]    ph_q;
  logic [NUM_SEL-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ph_q <= '0;
    else if (adv_i) ph_q <= ph_q + 1'b1;
  end

  // divisor 4^(g+1): tick when the low 2(g+1) phase bits are all ones
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
    if (g < NUM_DIV) begin : g_on
      assign hit[g] = &ph_q[2*g+1:0];
    end else begin : g_off
      assign hit[g] = 1'b0;
    end
  end

  assign tick_o = adv_i & hit[sel_i];
endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_DIV = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             uf_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             flag_o
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             flag_q;

  always_comb begin
    ctl_d = wdata_i & CTL_STORE_MASK;
    if (wdata_i[PSEL_W-1:0] >= PSEL_W'(NUM_DIV)) ctl_d[PSEL_W-1:0] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (wr_i) ctl_q <= ctl_d;
  end

  // flag is set only by hardware; software may only clear it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      flag_q <= 1'b0;
    else if (uf_i)                    flag_q <= 1'b1;
    else if (wr_i && !wdata_i[UF_BIT]) flag_q <= 1'b0;
  end

  assign ctl_o  = ctl_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int unsigned      CNT_W   = 32,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rel_wr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rel_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q, rel_q;

  assign uf_o = tick_i & ~cnt_wr_i & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= RST_VAL;
    else if (cnt_wr_i) cnt_q <= wdata_i;
    else if (uf_o)     cnt_q <= rel_q;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rel_q <= RST_VAL;
    else if (rel_wr_i) rel_q <= wdata_i;
  end

  assign cnt_o = cnt_q;
  assign rel_o = rel_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_DIV = 5,
  parameter int unsigned AW      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  reg_idx_e         idx;
  logic             rel_wr, cnt_wr, ctl_wr, sto_wr;
  logic             adv, tick, uf, flag;
  logic [CNT_W-1:0] cnt, rel, sto_q;
  logic [CTL_W-1:0] ctl, ctl_rd;

  assign idx    = reg_idx_e'(addr_i[3:2]);
  assign rel_wr = wr_i && (idx == REG_RELOAD);
  assign cnt_wr = wr_i && (idx == REG_COUNT);
  assign ctl_wr = wr_i && (idx == REG_CTRL);
  assign sto_wr = wr_i && (idx == REG_STORE);

  // a control write holds the prescaler for that cycle
  assign adv = run_i & ~ctl_wr;

  tmr_prescale #(.NUM_DIV(NUM_DIV), .SEL_W(PSEL_W)) i_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .sel_i (ctl[PSEL_W-1:0]),
    .tick_o(tick)
  );

  tmr_down_cnt #(.CNT_W(CNT_W), .RST_VAL('1)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .rel_wr_i(rel_wr),
    .cnt_wr_i(cnt_wr),
    .wdata_i (wdata_i),
    .cnt_o   (cnt),
    .rel_o   (rel),
    .uf_o    (uf)
  );

  tmr_ctrl_reg #(.NUM_DIV(NUM_DIV)) i_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (ctl_wr),
    .wdata_i(wdata_i[CTL_W-1:0]),
    .uf_i   (uf),
    .ctl_o  (ctl),
    .flag_o (flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sto_q <= '0;
    else if (sto_wr) sto_q <= wdata_i;
  end

  always_comb begin
    ctl_rd         = ctl;
    ctl_rd[UF_BIT] = flag;
  end

  always_comb begin
    unique case (idx)
      REG_RELOAD: rdata_o = rel;
      REG_COUNT:  rdata_o = cnt;
      REG_CTRL:   rdata_o = CNT_W'(ctl_rd);
      default:    rdata_o = sto_q;
    endcase
  end

  assign irq_o = flag & ctl[IE_BIT];
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             ctl_wr_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             tick_i,
  input logic             uf_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] rel_i,
  input logic             flag_i,
  input logic             irq_i
);
  assert_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_i));

  assert_ctl_pause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i |-> !tick_i);

  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr_i && cnt_i != '0) |=> cnt_i == $past(cnt_i) - 1'b1);

  assert_reload_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> (cnt_i == $past(rel_i)) && flag_i);

  assert_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_i == $past(wdata_i)) && (flag_i == $past(flag_i)));

  assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !wdata_i[8]) |=> !flag_i);

  assert_flag_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && wdata_i[8]) |=> flag_i == $past(flag_i));

  assert_flag_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(uf_i));

  assert_irq_needs_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> flag_i);
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .ctl_wr_i(ctl_wr),
  .cnt_wr_i(cnt_wr),
  .wdata_i (wdata_i),
  .tick_i  (tick),
  .uf_i    (uf),
  .cnt_i   (cnt),
  .rel_i   (rel),
  .flag_i  (flag),
  .irq_i   (irq_o)
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model
  int          m_ph = 0;
  logic [31:0] m_cnt = '1, m_rel = '1, m_sto = '0;
  logic [15:0] m_ctl = '0;
  logic        m_uf = 1'b0;

  tmr_channel i_tmr_channel (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    addr_i = 4'(idx * 4);
    #1;
    v = rdata_o;
  endtask

  function automatic int div_of(input logic [15:0] c);
    return 4 << (2 * int'(c[2:0]));
  endfunction

  function automatic logic [15:0] san(input logic [15:0] d);
    logic [15:0] s;
    s = d & 16'h00FF;
    if (s[2:0] > 3'd4) s[2:0] = 3'd0;
    return s;
  endfunction

  // one clock: drive at mid-low, update model at the edge
  task automatic cyc(input logic run, input logic we, input int idx, input logic [31:0] d);
    int          dv;
    logic        is_cw, adv, tk;
    logic [31:0] old_rel;
    run_i = run; wr_i = we; addr_i = 4'(idx * 4); wdata_i = d;
    dv      = div_of(m_ctl);
    is_cw   = we && (idx == 2);
    adv     = run && !is_cw;
    tk      = adv && ((m_ph % dv) == dv - 1);
    old_rel = m_rel;
    @(posedge clk_i);
    if (we) begin
      case (idx)
        0: m_rel = d;
        1: m_cnt = d;
        2: begin if (!d[8]) m_uf = 1'b0; m_ctl = san(d[15:0]); end
        default: m_sto = d;
      endcase
    end
    if (tk && !(we && idx == 1)) begin
      if (m_cnt == 0) begin m_cnt = old_rel; m_uf = 1'b1; end
      else m_cnt = m_cnt - 1;
    end
    if (adv) m_ph = (m_ph + 1) % 1024;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic chk_all(input string tag);
    logic [31:0] v;
    rd(1, v); cmp({tag, " count"}, v, m_cnt);
    rd(2, v); cmp({tag, " ctrl"}, v, {16'h0, m_ctl | (16'(m_uf) << 8)});
    cmp({tag, " irq"}, {31'h0, irq_o}, {31'h0, m_uf & m_ctl[5]});
  endtask

  function automatic logic next_uf();
    int dv;
    dv = div_of(m_ctl);
    return ((m_ph % dv) == dv - 1) && (m_cnt == 0);
  endfunction

  task automatic run_to_uf_edge();
    int guard;
    guard = 0;
    while (!next_uf() && guard < 5000) begin
      cyc(1'b1, 1'b0, 0, 32'h0);
      guard++;
    end
    if (guard >= 5000) cmp("R10/R11 seek", 32'(guard), 32'h0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(0, v); cmp("R1 reload", v, 32'hFFFF_FFFF);
    rd(1, v); cmp("R1 count", v, 32'hFFFF_FFFF);
    rd(2, v); cmp("R1 ctrl", v, 32'h0);
    rd(3, v); cmp("R1 store", v, 32'h0);
    cmp("R1 irq", {31'h0, irq_o}, 32'h0);
    repeat (8) cyc(1'b0, 1'b0, 0, 32'h0);
    chk_all("R1 stopped");

    // R2 register map
    cyc(1'b0, 1'b1, 3, 32'hA5A5_5A5A);
    cyc(1'b0, 1'b1, 0, 32'h1234_5678);
    rd(3, v); cmp("R2 store", v, 32'hA5A5_5A5A);
    rd(0, v); cmp("R2 reload", v, 32'h1234_5678);
    chk_all("R2 map");

    // R3 R4 R9 sweep over all prescale codes
    for (int code = 0; code < 5; code++) begin
      cyc(1'b0, 1'b1, 2, 32'(code) | 32'h20);
      cyc(1'b0, 1'b1, 0, 32'd2);
      cyc(1'b0, 1'b1, 1, 32'd1);
      for (int k = 0; k < (4 << (2 * code)) * 6 + 3; k++) begin
        cyc(1'b1, 1'b0, 0, 32'h0);
        chk_all("R3 R4 R9 sweep");
      end
    end

    // R5 freeze and resume
    cyc(1'b0, 1'b1, 2, 32'h0000_0120);
    for (int k = 0; k < 40; k++) begin
      cyc(1'b0, 1'b0, 0, 32'h0);
      chk_all("R5 frozen");
    end
    for (int k = 0; k < 40; k++) begin
      cyc(1'b1, 1'b0, 0, 32'h0);
      chk_all("R5 resumed");
    end

    // R6 control writes while running hold the phase
    for (int k = 0; k < 30; k++) begin
      cyc(1'b1, (k % 3) == 0, 2, 32'h0000_0120);
      chk_all("R6 pause");
    end

    // R7 flag keep and clear
    run_to_uf_edge();
    cyc(1'b1, 1'b0, 0, 32'h0);
    chk_all("R7 flag set");
    cmp("R7 flag present", {31'h0, m_uf}, 32'h1);
    cyc(1'b1, 1'b1, 2, 32'h0000_0120);
    chk_all("R7 keep");
    cyc(1'b1, 1'b1, 2, 32'h0000_0020);
    chk_all("R7 clear");

    // R8 read-back masking, R9 enable off
    run_to_uf_edge();
    cyc(1'b1, 1'b0, 0, 32'h0);
    cyc(1'b0, 1'b1, 2, 32'h0000_FFFF);
    rd(2, v); cmp("R8 reserved", v, 32'h0000_01F8);
    cyc(1'b0, 1'b1, 2, 32'hFFFF_0106);
    rd(2, v); cmp("R8 code6", v, 32'h0000_0100);
    chk_all("R9 ie off");
    cyc(1'b0, 1'b1, 2, 32'h0000_0104);
    rd(2, v); cmp("R8 code4", v, 32'h0000_0104);
    cyc(1'b0, 1'b1, 2, 32'h0000_0025);
    chk_all("R8 code5");

    // R10 counter write on an underflow tick
    cyc(1'b0, 1'b1, 2, 32'h0000_0020);
    cyc(1'b0, 1'b1, 0, 32'd7);
    cyc(1'b0, 1'b1, 1, 32'd0);
    run_to_uf_edge();
    cyc(1'b1, 1'b1, 1, 32'h55);
    chk_all("R10 collide");
    cmp("R10 count", m_cnt, 32'h55);

    // R11 reload write on an underflow tick
    cyc(1'b0, 1'b1, 0, 32'd9);
    cyc(1'b0, 1'b1, 1, 32'd0);
    run_to_uf_edge();
    cyc(1'b1, 1'b1, 0, 32'h33);
    chk_all("R11 collide");
    rd(1, v); cmp("R11 old reload", v, 32'd9);
    rd(0, v); cmp("R11 new reload", v, 32'h33);
    cyc(1'b1, 1'b1, 2, 32'h0000_0020);
    cyc(1'b1, 1'b1, 1, 32'd0);
    run_to_uf_edge();
    cyc(1'b1, 1'b0, 0, 32'h0);
    chk_all("R11 later");
    rd(1, v); cmp("R11 new used", v, 32'h33);

    finish_run();
  end
endmodule